// File: doc/BRIEF.md
# Direct-Mapped Data Cache

This block is a direct-mapped cache placed between a 32-bit processor's load/store port and a slower memory that moves whole lines. With the default parameters it holds 16 KB in 1024 lines of four 32-bit words. Each access address is cut into a tag, a line index and a byte offset. The indexed line's valid bit and stored tag decide between a hit and a miss. A read hit returns its word in the same cycle the request is presented. A miss holds the processor until the whole line has been fetched and installed. The held request then completes as a hit.

One parameter picks the write policy. In write-back mode a store changes only the cached line and marks it dirty. A dirty line goes out to memory before another line takes its slot, and a store miss first brings the line in. In write-through mode a store hit updates the cached word and also queues a word-masked write in a small write buffer. A store miss only queues the write and leaves the cache as it was. A store that finds the buffer full waits. A flush input walks every line, writes back the dirty ones and leaves every line invalid.

The processor side uses a level request that the processor holds with a stable address until a one-cycle done pulse. The memory side uses a request held until a one-cycle acknowledge. That interface carries a line address, four data words and a 16-bit byte mask.

Top module: `dm_cache`

## Requirements
- R1: Address bits [31:14] form the tag, bits [13:4] the line index and bits [3:0] the byte offset, with bits [3:2] picking the word. Address 0x12345678 maps to index 0x167 and word 2, and its line address on the memory port is 0x1234567 (address bits [31:4]).
- R2: After reset no line is valid and no request is pending: cpu_done, mem_req and flush_busy are low, and the first read of any address misses.
- R3: A read whose line is valid with a matching tag raises cpu_done in the same cycle the request is presented, returns the cached word on cpu_rdata and makes no memory request.
- R4: A read to an invalid line issues exactly one memory read (mem_we low) of the request's line address and no memory write, then returns the selected word of the fetched line.
- R5: A miss on a valid line that holds another tag and is clean discards that line without any memory write and fetches the requested line.
- R6: In write-back mode a store hit changes only the bytes whose cpu_be bit is set (bit n covers data bits 8n+7:8n), completes in the cycle it is presented and causes no memory traffic.
- R7: In write-back mode a miss on a dirty line first writes the old line to memory at address {stored tag, index} with all 16 mask bits set, and only then reads the new line.
- R8: In write-back mode a store miss fetches the line, merges the store into it and leaves memory unchanged until the line is written back.
- R9: In write-through mode a store hit updates the cached word, completes without waiting for memory, and later writes memory with mask bit 4w+n set for each enabled byte n of word w only.
- R10: In write-through mode a store miss is queued to memory without allocating, so a later read of that address misses and returns the stored value.
- R11: In write-through mode a store that finds the write buffer full is held (cpu_done low) until an entry drains, while stores that find room complete at once.
- R12: A flush_req pulse raises flush_busy while every line is visited. Each dirty line is written back. Afterwards every line is invalid, and no processor access completes while flush_busy is high.
- R13: On every miss cpu_done stays low until the needed line has arrived from memory. A memory request that has not been acknowledged keeps its address and direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Processor access request, held until cpu_done |
| cpu_we | input | 1 | 1 for store, 0 for load |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_be | input | 4 | Byte enables for a store |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid with cpu_done |
| cpu_done | output | 1 | Access completes this cycle |
| flush_req | input | 1 | Start a walk over all lines |
| flush_busy | output | 1 | Flush walk in progress |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | 1 for memory write, 0 for line read |
| mem_addr | output | 28 | Line address (byte address bits 31:4) |
| mem_wmask | output | 16 | Byte mask of the write line |
| mem_wdata | output | 128 | Write line, word w at bits 32w+31:32w |
| mem_rdata | input | 128 | Read line, valid with mem_ack |
| mem_ack | input | 1 | One-cycle completion of a memory request |

## Verification
The properties assume that the processor holds cpu_req, cpu_we, cpu_addr, cpu_be and cpu_wdata steady from raising a request until the cycle of cpu_done. They also assume that memory raises mem_ack for one cycle and only while mem_req is high. The bench drives each access from a task that keeps these inputs still until done is seen and then drops the request. Its memory models answer with a fixed latency and return an acknowledge only for a request they are serving. Flush pulses are issued only while no processor access is pending.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
    localparam int ADDR_W = 32;
    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVICT,
        ST_FILL,
        ST_FLUSH,
        ST_FLUSH_WB
    } cst_e;
endpackage

// File: rtl/dcache_tag_store.sv
module dcache_tag_store #(
    parameter int LINES = 1024,
    parameter int TAG_W = 18,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic             rd_dirty,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_valid,
    input  logic             wr_dirty,
    input  logic [TAG_W-1:0] wr_tag
);
    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;
    logic [TAG_W-1:0] tag_q [LINES];

    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= wr_valid;
            dirty_q[wr_idx] <= wr_dirty;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) tag_q[wr_idx] <= wr_tag;
    end
endmodule

// File: rtl/dcache_data_store.sv
module dcache_data_store import dcache_pkg::*; #(
    parameter int LINES = 1024,
    parameter int WORDS = 4,
    localparam int IDX_W  = $clog2(LINES),
    localparam int LINE_W = WORDS * WORD_W,
    localparam int MASK_W = LINE_W / BYTE_W
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [LINE_W-1:0] wr_line,
    input  logic [MASK_W-1:0] wr_mask
);
    logic [LINE_W-1:0] mem_q [LINES];

    assign rd_line = mem_q[rd_idx];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int b = 0; b < MASK_W; b++) begin
                if (wr_mask[b]) mem_q[wr_idx][b*BYTE_W +: BYTE_W] <= wr_line[b*BYTE_W +: BYTE_W];
            end
        end
    end
endmodule

// File: rtl/dcache_wbuf.sv
module dcache_wbuf #(
    parameter int DEPTH = 4,
    parameter int ENT_W = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [ENT_W-1:0] push_data,
    input  logic             pop,
    output logic [ENT_W-1:0] head,
    output logic             empty,
    output logic             full
);
    typedef struct packed {
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic [CNT_W-1:0] cnt;
    } fifo_t;

    fifo_t            fifo_d, fifo_q;
    logic [ENT_W-1:0] ent_q [DEPTH];
    logic             do_push, do_pop;

    assign empty   = (fifo_q.cnt == '0);
    assign full    = (fifo_q.cnt == CNT_W'(DEPTH));
    assign head    = ent_q[fifo_q.rd];
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_comb begin
        fifo_d = fifo_q;
        if (do_push) fifo_d.wr = (fifo_q.wr == PTR_W'(DEPTH - 1)) ? '0 : fifo_q.wr + 1'b1;
        if (do_pop)  fifo_d.rd = (fifo_q.rd == PTR_W'(DEPTH - 1)) ? '0 : fifo_q.rd + 1'b1;
        if (do_push && !do_pop)      fifo_d.cnt = fifo_q.cnt + 1'b1;
        else if (do_pop && !do_push) fifo_d.cnt = fifo_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fifo_q <= '0;
        else        fifo_q <= fifo_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) ent_q[fifo_q.wr] <= push_data;
    end
endmodule

// File: rtl/dm_cache.sv
module dm_cache import dcache_pkg::*; #(
    parameter int LINES      = 1024,
    parameter int WORDS      = 4,
    parameter int WRITE_BACK = 1,
    parameter int WBUF_DEPTH = 4,
    localparam int LINE_W = WORDS * WORD_W,
    localparam int MASK_W = LINE_W / BYTE_W,
    localparam int OFF_W  = $clog2(MASK_W),
    localparam int IDX_W  = $clog2(LINES),
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
    localparam int LA_W   = ADDR_W - OFF_W,
    localparam int WSEL_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [31:0]       cpu_addr,
    input  logic [3:0]        cpu_be,
    input  logic [31:0]       cpu_wdata,
    output logic [31:0]       cpu_rdata,
    output logic              cpu_done,
    input  logic              flush_req,
    output logic              flush_busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [LA_W-1:0]   mem_addr,
    output logic [MASK_W-1:0] mem_wmask,
    output logic [LINE_W-1:0] mem_wdata,
    input  logic [LINE_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    localparam int ENT_W = LA_W + MASK_W + LINE_W;

    typedef struct packed {
        cst_e             st;
        logic [IDX_W-1:0] fidx;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    // address fields
    logic [TAG_W-1:0]  req_tag;
    logic [IDX_W-1:0]  req_idx;
    logic [WSEL_W-1:0] req_word;
    logic [LA_W-1:0]   req_la;
    logic [1:0]        unused_addr_bits;

    assign req_tag          = cpu_addr[ADDR_W-1 -: TAG_W];
    assign req_idx          = cpu_addr[OFF_W +: IDX_W];
    assign req_word         = cpu_addr[2 +: WSEL_W];
    assign req_la           = cpu_addr[ADDR_W-1:OFF_W];
    assign unused_addr_bits = cpu_addr[1:0];

    // lookup
    logic              walking;
    logic [IDX_W-1:0]  lk_idx;
    logic              rd_valid, rd_dirty, hit;
    logic [TAG_W-1:0]  rd_tag;
    logic [LINE_W-1:0] rd_line;

    assign walking = (ctl_q.st == ST_FLUSH) || (ctl_q.st == ST_FLUSH_WB);
    assign lk_idx  = walking ? ctl_q.fidx : req_idx;
    assign hit     = rd_valid && (rd_tag == req_tag);

    // store data placed at its word lanes
    logic [LINE_W-1:0] st_line;
    logic [MASK_W-1:0] st_mask;

    assign st_line = {WORDS{cpu_wdata}};
    assign st_mask = MASK_W'(cpu_be) << (req_word * 4);

    // array write controls
    logic              tw_en, tw_valid, tw_dirty;
    logic [TAG_W-1:0]  tw_tag;
    logic              dw_en;
    logic [LINE_W-1:0] dw_line;
    logic [MASK_W-1:0] dw_mask;

    // write buffer
    logic             wb_push, wb_pop, wb_empty, wb_full;
    logic [ENT_W-1:0] wb_head;

    generate
        if (WRITE_BACK == 0) begin : g_wt
            dcache_wbuf #(.DEPTH(WBUF_DEPTH), .ENT_W(ENT_W)) u_wbuf (
                .clk       (clk),
                .rst_n     (rst_n),
                .push      (wb_push),
                .push_data ({req_la, st_mask, st_line}),
                .pop       (wb_pop),
                .head      (wb_head),
                .empty     (wb_empty),
                .full      (wb_full)
            );
        end else begin : g_wb
            logic unused_wb;
            assign unused_wb = wb_push ^ wb_pop;
            assign wb_head   = '0;
            assign wb_empty  = 1'b1;
            assign wb_full   = 1'b0;
        end
    endgenerate

    always_comb begin
        ctl_d     = ctl_q;
        cpu_done  = 1'b0;
        tw_en     = 1'b0;
        tw_valid  = 1'b0;
        tw_dirty  = 1'b0;
        tw_tag    = req_tag;
        dw_en     = 1'b0;
        dw_line   = st_line;
        dw_mask   = st_mask;
        wb_push   = 1'b0;
        wb_pop    = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = req_la;
        mem_wmask = '1;
        mem_wdata = rd_line;

        // write-through drain: runs whenever entries are queued
        if (WRITE_BACK == 0 && !wb_empty) begin
            mem_req = 1'b1;
            mem_we  = 1'b1;
            {mem_addr, mem_wmask, mem_wdata} = wb_head;
            wb_pop  = mem_ack;
        end

        case (ctl_q.st)
            ST_IDLE: begin
                if (flush_req) begin
                    ctl_d.st   = ST_FLUSH;
                    ctl_d.fidx = '0;
                end else if (cpu_req) begin
                    if (hit) begin
                        if (!cpu_we) begin
                            cpu_done = 1'b1;
                        end else if (WRITE_BACK != 0) begin
                            dw_en    = 1'b1;
                            tw_en    = 1'b1;
                            tw_valid = 1'b1;
                            tw_dirty = 1'b1;
                            cpu_done = 1'b1;
                        end else if (!wb_full) begin
                            dw_en    = 1'b1;
                            wb_push  = 1'b1;
                            cpu_done = 1'b1;
                        end
                    end else if (cpu_we && WRITE_BACK == 0) begin
                        if (!wb_full) begin
                            wb_push  = 1'b1;
                            cpu_done = 1'b1;
                        end
                    end else if (wb_empty) begin
                        ctl_d.st = (WRITE_BACK != 0 && rd_valid && rd_dirty) ? ST_EVICT : ST_FILL;
                    end
                end
            end
            ST_EVICT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {rd_tag, req_idx};
                mem_wmask = '1;
                mem_wdata = rd_line;
                if (mem_ack) ctl_d.st = ST_FILL;
            end
            ST_FILL: begin
                mem_req  = 1'b1;
                mem_we   = 1'b0;
                mem_addr = req_la;
                if (mem_ack) begin
                    dw_en    = 1'b1;
                    dw_line  = mem_rdata;
                    dw_mask  = '1;
                    tw_en    = 1'b1;
                    tw_valid = 1'b1;
                    ctl_d.st = ST_IDLE;
                end
            end
            ST_FLUSH: begin
                tw_tag = rd_tag;
                if (WRITE_BACK != 0 && rd_valid && rd_dirty) begin
                    ctl_d.st = ST_FLUSH_WB;
                end else begin
                    tw_en = 1'b1;
                    if (ctl_q.fidx == IDX_W'(LINES - 1)) ctl_d.st = ST_IDLE;
                    else ctl_d.fidx = ctl_q.fidx + 1'b1;
                end
            end
            ST_FLUSH_WB: begin
                tw_tag    = rd_tag;
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {rd_tag, ctl_q.fidx};
                mem_wmask = '1;
                mem_wdata = rd_line;
                if (mem_ack) begin
                    tw_en = 1'b1;
                    if (ctl_q.fidx == IDX_W'(LINES - 1)) begin
                        ctl_d.st = ST_IDLE;
                    end else begin
                        ctl_d.st   = ST_FLUSH;
                        ctl_d.fidx = ctl_q.fidx + 1'b1;
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: ST_IDLE, fidx: '0};
        else        ctl_q <= ctl_d;
    end

    assign flush_busy = walking;
    assign cpu_rdata  = rd_line[req_word*WORD_W +: WORD_W];

    dcache_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (lk_idx),
        .rd_valid (rd_valid),
        .rd_dirty (rd_dirty),
        .rd_tag   (rd_tag),
        .wr_en    (tw_en),
        .wr_idx   (lk_idx),
        .wr_valid (tw_valid),
        .wr_dirty (tw_dirty),
        .wr_tag   (tw_tag)
    );

    dcache_data_store #(.LINES(LINES), .WORDS(WORDS)) u_data (
        .clk     (clk),
        .rd_idx  (lk_idx),
        .rd_line (rd_line),
        .wr_en   (dw_en),
        .wr_idx  (req_idx),
        .wr_line (dw_line),
        .wr_mask (dw_mask)
    );
endmodule

// File: rtl/dm_cache_chk.sv
module dm_cache_chk #(
    parameter int WRITE_BACK = 1,
    parameter int MASK_W     = 16,
    parameter int LA_W       = 28
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_done,
    input logic              flush_busy,
    input logic              mem_req,
    input logic              mem_we,
    input logic [LA_W-1:0]   mem_addr,
    input logic [MASK_W-1:0] mem_wmask,
    input logic              mem_ack
);
    p_mem_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    p_done_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |-> cpu_req);

    p_flush_no_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
        flush_busy |-> !cpu_done);

    p_no_done_during_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |-> !(mem_req && !mem_we));

    p_wb_full_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (WRITE_BACK != 0 && mem_req && mem_we) |-> (mem_wmask == {MASK_W{1'b1}}));

    p_wt_word_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (WRITE_BACK == 0 && mem_req && mem_we) |-> ($countones(mem_wmask) <= 4));
endmodule

bind dm_cache dm_cache_chk #(.WRITE_BACK(WRITE_BACK), .MASK_W(MASK_W), .LA_W(LA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_req    (cpu_req),
    .cpu_done   (cpu_done),
    .flush_busy (flush_busy),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wmask  (mem_wmask),
    .mem_ack    (mem_ack)
);

// File: tb/dm_cache_tb.sv
module dm_mem_model #(parameter int LAT = 3) (
    input  logic         clk,
    input  logic         req,
    input  logic         we,
    input  logic [27:0]  addr,
    input  logic [15:0]  wmask,
    input  logic [127:0] wdata,
    output logic [127:0] rdata,
    output logic         ack
);
    logic [127:0] store [logic [27:0]];
    int nrd = 0, nwr = 0, seq = 0, rd_seq = 0, wr_seq = 0, cnt = 0;
    logic [27:0]  last_raddr = '0, last_waddr = '0;
    logic [15:0]  last_wmask = '0;
    logic [127:0] last_wdata = '0;
    logic [127:0] cur;

    initial begin
        ack   = 1'b0;
        rdata = '0;
    end

    function automatic logic [127:0] line_of(input logic [27:0] a);
        logic [127:0] v;
        if (store.exists(a)) return store[a];
        for (int w = 0; w < 4; w++) v[w*32 +: 32] = {a, 2'(w), 2'b00};
        return v;
    endfunction

    always @(posedge clk) begin
        ack <= 1'b0;
        if (req && !ack) begin
            if (cnt >= LAT) begin
                cnt <= 0;
                ack <= 1'b1;
                seq <= seq + 1;
                if (we) begin
                    cur = line_of(addr);
                    for (int b = 0; b < 16; b++) if (wmask[b]) cur[b*8 +: 8] = wdata[b*8 +: 8];
                    store[addr] = cur;
                    nwr        <= nwr + 1;
                    wr_seq     <= seq + 1;
                    last_waddr <= addr;
                    last_wmask <= wmask;
                    last_wdata <= wdata;
                end else begin
                    rdata      <= line_of(addr);
                    nrd        <= nrd + 1;
                    rd_seq     <= seq + 1;
                    last_raddr <= addr;
                end
            end else begin
                cnt <= cnt + 1;
            end
        end
    end
endmodule

module dm_cache_tb;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        req_b = 1'b0, req_t = 1'b0, flush_b = 1'b0, flush_t = 1'b0;
    logic        we = 1'b0;
    logic [31:0] addr = '0, wdata = '0;
    logic [3:0]  be = '0;

    logic [31:0]  rdata_b, rdata_t;
    logic         done_b, done_t, busy_b, busy_t;
    logic         mreq_b, mwe_b, mack_b, mreq_t, mwe_t, mack_t;
    logic [27:0]  maddr_b, maddr_t;
    logic [15:0]  mmask_b, mmask_t;
    logic [127:0] mwd_b, mrd_b, mwd_t, mrd_t;

    int n_chk = 0, n_err = 0;

    dm_cache #(.WRITE_BACK(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(req_b), .cpu_we(we), .cpu_addr(addr),
        .cpu_be(be), .cpu_wdata(wdata), .cpu_rdata(rdata_b), .cpu_done(done_b),
        .flush_req(flush_b), .flush_busy(busy_b), .mem_req(mreq_b), .mem_we(mwe_b),
        .mem_addr(maddr_b), .mem_wmask(mmask_b), .mem_wdata(mwd_b),
        .mem_rdata(mrd_b), .mem_ack(mack_b));

    dm_cache #(.WRITE_BACK(0), .WBUF_DEPTH(2)) u_dut_wt (
        .clk(clk), .rst_n(rst_n), .cpu_req(req_t), .cpu_we(we), .cpu_addr(addr),
        .cpu_be(be), .cpu_wdata(wdata), .cpu_rdata(rdata_t), .cpu_done(done_t),
        .flush_req(flush_t), .flush_busy(busy_t), .mem_req(mreq_t), .mem_we(mwe_t),
        .mem_addr(maddr_t), .mem_wmask(mmask_t), .mem_wdata(mwd_t),
        .mem_rdata(mrd_t), .mem_ack(mack_t));

    dm_mem_model #(.LAT(3)) u_mem_b (
        .clk(clk), .req(mreq_b), .we(mwe_b), .addr(maddr_b), .wmask(mmask_b),
        .wdata(mwd_b), .rdata(mrd_b), .ack(mack_b));

    dm_mem_model #(.LAT(20)) u_mem_t (
        .clk(clk), .req(mreq_t), .we(mwe_t), .addr(maddr_t), .wmask(mmask_t),
        .wdata(mwd_t), .rdata(mrd_t), .ack(mack_t));

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic acc(input bit wt, input bit w, input logic [31:0] a, input logic [3:0] b,
                       input logic [31:0] d, output logic [31:0] rd, output int cyc);
        @(negedge clk);
        we = w; addr = a; be = b; wdata = d;
        if (wt) req_t = 1'b1; else req_b = 1'b1;
        cyc = 0;
        #1;
        while (!(wt ? done_t : done_b)) begin
            @(negedge clk);
            #1;
            cyc++;
        end
        rd = wt ? rdata_t : rdata_b;
        @(posedge clk);
        #1;
        req_t = 1'b0; req_b = 1'b0; we = 1'b0;
    endtask

    task automatic wait_wt_writes(input int target);
        for (int i = 0; i < 400 && u_mem_t.nwr < target; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R2 done low after reset", 128'(done_b), 128'(0));
        chk("R2 mem_req low after reset", 128'(mreq_b | mreq_t), 128'(0));
        chk("R2 flush_busy low after reset", 128'(busy_b), 128'(0));
    endtask

    task automatic t_wb_read_miss_hit();
        logic [31:0] rd; int cyc; int r0, w0;
        r0 = u_mem_b.nrd; w0 = u_mem_b.nwr;
        acc(0, 0, 32'h1234_5678, 4'h0, 32'h0, rd, cyc);
        chk("R4 one line read", 128'(u_mem_b.nrd - r0), 128'(1));
        chk("R4 no write on invalid miss", 128'(u_mem_b.nwr - w0), 128'(0));
        chk("R1 line address of 0x12345678", 128'(u_mem_b.last_raddr), 128'(28'h123_4567));
        chk("R4 returned word", 128'(rd), 128'(32'h1234_5678));
        chk("R13 miss held done low", 128'(cyc > 3), 128'(1));
        acc(0, 0, 32'h1234_5674, 4'h0, 32'h0, rd, cyc);
        chk("R3 hit in first cycle", 128'(cyc), 128'(0));
        chk("R3 hit data", 128'(rd), 128'(32'h1234_5674));
        chk("R3 hit no memory read", 128'(u_mem_b.nrd - r0), 128'(1));
    endtask

    task automatic t_wb_store_evict();
        logic [31:0] rd; int cyc; int r0, w0;
        r0 = u_mem_b.nrd; w0 = u_mem_b.nwr;
        acc(0, 1, 32'h1234_5678, 4'b0011, 32'hAABB_CCDD, rd, cyc);
        chk("R6 store hit immediate", 128'(cyc), 128'(0));
        acc(0, 0, 32'h1234_5678, 4'h0, 32'h0, rd, cyc);
        chk("R6 byte-merged word", 128'(rd), 128'(32'h1234_CCDD));
        chk("R6 no memory traffic", 128'((u_mem_b.nrd - r0) + (u_mem_b.nwr - w0)), 128'(0));
        // same index 0x167 (R1), tag 0 instead of 0x48D1
        acc(0, 0, 32'h0000_5678, 4'h0, 32'h0, rd, cyc);
        chk("R7 one write-back", 128'(u_mem_b.nwr - w0), 128'(1));
        chk("R7 write-back address", 128'(u_mem_b.last_waddr), 128'(28'h123_4567));
        chk("R7 write-back mask", 128'(u_mem_b.last_wmask), 128'(16'hFFFF));
        chk("R7 write-back word", 128'(u_mem_b.last_wdata[95:64]), 128'(32'h1234_CCDD));
        chk("R7 write before read", 128'(u_mem_b.wr_seq < u_mem_b.rd_seq), 128'(1));
        chk("R7 new line data", 128'(rd), 128'(32'h0000_5678));
        w0 = u_mem_b.nwr; r0 = u_mem_b.nrd;
        acc(0, 0, 32'h1234_5678, 4'h0, 32'h0, rd, cyc);
        chk("R5 clean conflict no write", 128'(u_mem_b.nwr - w0), 128'(0));
        chk("R5 clean conflict refetch", 128'(u_mem_b.nrd - r0), 128'(1));
        chk("R5 refetched written-back data", 128'(rd), 128'(32'h1234_CCDD));
    endtask

    task automatic t_wb_alloc_flush();
        logic [31:0] rd; int cyc; int r0, w0; logic [127:0] ml; bit saw;
        r0 = u_mem_b.nrd; w0 = u_mem_b.nwr;
        acc(0, 1, 32'h00AB_C004, 4'hF, 32'hDEAD_BEEF, rd, cyc);
        chk("R8 store miss fetches line", 128'(u_mem_b.nrd - r0), 128'(1));
        chk("R8 store miss no write", 128'(u_mem_b.nwr - w0), 128'(0));
        acc(0, 0, 32'h00AB_C004, 4'h0, 32'h0, rd, cyc);
        chk("R8 allocated line holds store", 128'(rd), 128'(32'hDEAD_BEEF));
        chk("R8 allocated read hits", 128'(cyc), 128'(0));
        ml = u_mem_b.line_of(28'h00A_BC00);
        chk("R8 memory unchanged", 128'(ml[63:32]), 128'(32'h00AB_C004));
        @(negedge clk); flush_b = 1'b1;
        @(negedge clk); flush_b = 1'b0;
        saw = busy_b;
        chk("R12 flush_busy raised", 128'(saw), 128'(1));
        for (int i = 0; i < 5000 && busy_b; i++) @(negedge clk);
        chk("R12 flush ended", 128'(busy_b), 128'(0));
        chk("R12 one dirty write-back", 128'(u_mem_b.nwr - w0), 128'(1));
        chk("R12 write-back address", 128'(u_mem_b.last_waddr), 128'(28'h00A_BC00));
        chk("R12 write-back data", 128'(u_mem_b.last_wdata[63:32]), 128'(32'hDEAD_BEEF));
        r0 = u_mem_b.nrd;
        acc(0, 0, 32'h1234_5678, 4'h0, 32'h0, rd, cyc);
        chk("R12 clean line invalid after flush", 128'(u_mem_b.nrd - r0), 128'(1));
        acc(0, 0, 32'h00AB_C004, 4'h0, 32'h0, rd, cyc);
        chk("R12 dirty line invalid after flush", 128'(u_mem_b.nrd - r0), 128'(2));
        chk("R12 data survives in memory", 128'(rd), 128'(32'hDEAD_BEEF));
    endtask

    task automatic t_wt_store_hit();
        logic [31:0] rd; int cyc; int w0;
        acc(1, 0, 32'h1234_5678, 4'h0, 32'h0, rd, cyc);
        w0 = u_mem_t.nwr;
        acc(1, 1, 32'h1234_5678, 4'b1100, 32'h1122_3344, rd, cyc);
        chk("R9 store hit no wait", 128'(cyc), 128'(0));
        acc(1, 0, 32'h1234_5678, 4'h0, 32'h0, rd, cyc);
        chk("R9 cache word updated", 128'(rd), 128'(32'h1122_5678));
        wait_wt_writes(w0 + 1);
        chk("R9 memory written once", 128'(u_mem_t.nwr - w0), 128'(1));
        chk("R9 word mask", 128'(u_mem_t.last_wmask), 128'(16'h0C00));
        chk("R9 write address", 128'(u_mem_t.last_waddr), 128'(28'h123_4567));
        chk("R9 write data", 128'(u_mem_t.last_wdata[95:64]), 128'(32'h1122_3344));
    endtask

    task automatic t_wt_miss_full();
        logic [31:0] rd; int c1, c2, c3, cyc; int w0, r0;
        w0 = u_mem_t.nwr;
        acc(1, 1, 32'h4000_0010, 4'hF, 32'h0000_0001, rd, c1);
        acc(1, 1, 32'h4000_0020, 4'hF, 32'h0000_0002, rd, c2);
        acc(1, 1, 32'h4000_0030, 4'hF, 32'h0000_0003, rd, c3);
        chk("R11 first store has room", 128'(c1), 128'(0));
        chk("R11 second store has room", 128'(c2), 128'(0));
        chk("R11 third store held while full", 128'(c3 > 0), 128'(1));
        wait_wt_writes(w0 + 3);
        chk("R10 three queued writes", 128'(u_mem_t.nwr - w0), 128'(3));
        chk("R10 miss store word mask", 128'(u_mem_t.last_wmask), 128'(16'h000F));
        r0 = u_mem_t.nrd;
        acc(1, 0, 32'h4000_0020, 4'h0, 32'h0, rd, cyc);
        chk("R10 no allocate so read misses", 128'(u_mem_t.nrd - r0), 128'(1));
        chk("R10 read returns stored value", 128'(rd), 128'(32'h0000_0002));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_wb_read_miss_hit();
        t_wb_store_evict();
        t_wb_alloc_flush();
        t_wt_store_hit();
        t_wt_miss_full();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule